// File: doc/BRIEF.md
# Fixed-Point Matrix-Vector Multiplier

This block computes b = C·x, where C is a matrix with n rows and m = 3n columns and x is a vector of length m. All operands are held in memories outside the block, and so are the results. A one-cycle start pulse launches a job. The block then walks the matrix row by row and, within each row, column by column. It issues one matrix read address and one vector read address per cycle. Both memories are synchronous and return data one cycle after the address.

Each element pair is multiplied in signed Q1.15. The full Q2.30 product is added into a wide accumulator register with guard bits, so no intermediate sum can overflow. When the last product of a row has been added, the sum is rounded to Q1.15 (half an LSB is added, then an arithmetic shift) and saturated. It is then written to the result memory with a single write strobe.

The matrix is read as one contiguous row-major block starting at its base address. An idle flag tells the host when a job is finished and a new start will be accepted.

Top module: `matvec_top`

## Requirements
- R1: While reset is applied and in the cycle after it is released, `idle` is 1 and `res_we` is 0.
- R2: After an accepted start, `mat_addr` begins at the latched `mat_base` and then rises by exactly 1 per issued element across all n·m elements (row-major, element address = base + row·m + col, modulo 2^ADDR_W).
- R3: `vec_addr` equals the latched `vec_base` for column 0 of every row and rises by 1 per column within the row.
- R4: Each job produces exactly n writes, in ascending row order, at `res_base + row`. Row r's data is the Q1.15 rounding of the sum over c of C[r][c]·x[c]. Rounding adds 2^14 to the Q2.30 sum and then shifts it arithmetically right by 15.
- R5: A rounded row result above 32767 is written as 16'h7FFF, and one below -32768 as 16'h8000.
- R6: The accumulator restarts at zero on every row, so a row's result does not depend on the data of earlier rows or earlier jobs.
- R7: A start pulse while `idle` is 0 is ignored. The running job keeps its base addresses and its element stream, and no extra job follows it.
- R8: `idle` falls in the cycle after an accepted start. It rises again in the cycle after the last row's write strobe.
- R9: Products are accumulated at full Q2.30 precision. A row whose partial sums leave the Q1.15 range, but whose final sum lies inside it, gives the exact rounded result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch pulse, accepted only while idle |
| mat_base | input | ADDR_W | Address of matrix element (0,0) |
| vec_base | input | ADDR_W | Address of vector element 0 |
| res_base | input | ADDR_W | Address for the result of row 0 |
| mat_addr | output | ADDR_W | Matrix memory read address |
| vec_addr | output | ADDR_W | Vector memory read address |
| mat_data | input | 16 | Matrix element in Q1.15, one cycle after its address |
| vec_data | input | 16 | Vector element in Q1.15, one cycle after its address |
| res_addr | output | ADDR_W | Result memory write address |
| res_data | output | 16 | Row result in Q1.15 |
| res_we | output | 1 | Result write strobe, one cycle per row |
| idle | output | 1 | No job in flight; start is accepted |

## Verification
Suppose a row or column counter slips, or the first-column tag is lost. The next write then shows a wrong value, a wrong address, or one write too many or too few, and that happens within m + 3 cycles of the fault. A stale accumulator shows up in the very next row's result, because the test vectors are chosen so that rows differ. A fault in the rounding or saturation stage corrupts `res_data` in the same cycle that `res_we` is asserted. Jobs with exact half-LSB sums and with saturating sums are there to expose it.

// File: rtl/matvec_pkg.sv
package matvec_pkg;

    localparam int DATA_W    = 16;
    localparam int FRAC_W    = 15;
    localparam int ACC_MAX_W = 48;

    typedef enum logic [0:0] {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_e;

    // Travels with each issued element pair through the read latency.
    typedef struct packed {
        logic valid;
        logic first;  // column 0 of its row
        logic last;   // final column of its row
    } elem_tag_t;

    // Q2.30 sum (sign-extended) -> Q1.15 with round-half-up and saturation.
    function automatic logic signed [DATA_W-1:0] q15_round_sat(
        input logic signed [ACC_MAX_W-1:0] v
    );
        logic signed [ACC_MAX_W-1:0] biased;
        logic signed [ACC_MAX_W-1:0] shifted;
        biased  = v + (ACC_MAX_W'(1) <<< (FRAC_W - 1));
        shifted = biased >>> FRAC_W;
        if (shifted > ACC_MAX_W'(32767))
            return 16'sh7FFF;
        else if (shifted < -ACC_MAX_W'(32768))
            return 16'sh8000;
        else
            return shifted[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/matvec_addr_gen.sv
module matvec_addr_gen
    import matvec_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int ADDR_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 launch,
    input  logic [ADDR_W-1:0]    mat_base,
    input  logic [ADDR_W-1:0]    vec_base,
    input  logic [ADDR_W-1:0]    res_base,
    output logic [ADDR_W-1:0]    mat_addr,
    output logic [ADDR_W-1:0]    vec_addr,
    output elem_tag_t            tag,
    output logic [(ROWS>1 ? $clog2(ROWS) : 1)-1:0] tag_row,
    output logic [ADDR_W-1:0]    res_base_q,
    output logic                 busy
);
    localparam int COLS = 3 * ROWS;
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CW   = $clog2(COLS);

    gen_state_e          state;
    logic [RW-1:0]       row;
    logic [CW-1:0]       col;
    logic [ADDR_W-1:0]   mptr;
    logic [ADDR_W-1:0]   vb_q;
    logic                col_end;
    logic                row_end;

    assign col_end = (col == CW'(COLS - 1));
    assign row_end = (row == RW'(ROWS - 1));
    assign busy    = (state == GEN_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= GEN_IDLE;
            row        <= '0;
            col        <= '0;
            mptr       <= '0;
            vb_q       <= '0;
            res_base_q <= '0;
            mat_addr   <= '0;
            vec_addr   <= '0;
            tag        <= '0;
            tag_row    <= '0;
        end else begin
            tag <= '0;
            unique case (state)
                GEN_IDLE: begin
                    if (launch) begin
                        state      <= GEN_RUN;
                        row        <= '0;
                        col        <= '0;
                        mptr       <= mat_base;
                        vb_q       <= vec_base;
                        res_base_q <= res_base;
                    end
                end
                GEN_RUN: begin
                    // Row-major storage: the matrix pointer only ever steps by one.
                    mat_addr  <= mptr;
                    vec_addr  <= vb_q + ADDR_W'(col);
                    tag.valid <= 1'b1;
                    tag.first <= (col == '0);
                    tag.last  <= col_end;
                    tag_row   <= row;
                    mptr      <= mptr + 1'b1;
                    if (col_end) begin
                        col <= '0;
                        if (row_end)
                            state <= GEN_IDLE;
                        else
                            row <= row + 1'b1;
                    end else begin
                        col <= col + 1'b1;
                    end
                end
                default: state <= GEN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/matvec_mac.sv
module matvec_mac
    import matvec_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int ADDR_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DATA_W-1:0]    mat_data,
    input  logic [DATA_W-1:0]    vec_data,
    input  elem_tag_t            tag_in,
    input  logic [(ROWS>1 ? $clog2(ROWS) : 1)-1:0] row_in,
    input  logic [ADDR_W-1:0]    res_base_in,
    output logic [ADDR_W-1:0]    res_addr,
    output logic [DATA_W-1:0]    res_data,
    output logic                 res_we,
    output logic                 busy
);
    localparam int COLS  = 3 * ROWS;
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int GUARD = $clog2(COLS) + 1;
    localparam int PROD_W = 2 * DATA_W;
    localparam int ACC_W = PROD_W + GUARD;

    elem_tag_t                  dtag;
    logic [RW-1:0]              drow;
    logic signed [ACC_W-1:0]    acc;
    logic signed [PROD_W-1:0]   prod;
    logic signed [ACC_W-1:0]    prod_ext;
    logic signed [ACC_W-1:0]    acc_in;
    logic signed [ACC_W-1:0]    sum;
    logic signed [ACC_MAX_W-1:0] sum_ext;

    // Memory data arrives one cycle after the address; align the tag with it.
    always_ff @(posedge clk) begin
        if (rst) begin
            dtag <= '0;
            drow <= '0;
        end else begin
            dtag <= tag_in;
            drow <= row_in;
        end
    end

    assign prod     = $signed(mat_data) * $signed(vec_data);
    assign prod_ext = {{GUARD{prod[PROD_W-1]}}, prod};
    assign acc_in   = dtag.first ? '0 : acc;
    assign sum      = acc_in + prod_ext;
    assign sum_ext  = {{(ACC_MAX_W-ACC_W){sum[ACC_W-1]}}, sum};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            res_we   <= 1'b0;
            res_addr <= '0;
            res_data <= '0;
        end else begin
            res_we <= 1'b0;
            if (dtag.valid) begin
                acc <= sum;
                if (dtag.last) begin
                    res_we   <= 1'b1;
                    res_addr <= res_base_in + ADDR_W'(drow);
                    res_data <= q15_round_sat(sum_ext);
                end
            end
        end
    end

    assign busy = dtag.valid | res_we;

endmodule

// File: rtl/matvec_top.sv
module matvec_top
    import matvec_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] mat_base,
    input  logic [ADDR_W-1:0] vec_base,
    input  logic [ADDR_W-1:0] res_base,
    output logic [ADDR_W-1:0] mat_addr,
    output logic [ADDR_W-1:0] vec_addr,
    input  logic [15:0]       mat_data,
    input  logic [15:0]       vec_data,
    output logic [ADDR_W-1:0] res_addr,
    output logic [15:0]       res_data,
    output logic              res_we,
    output logic              idle
);
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

    elem_tag_t           iss_tag;
    logic [RW-1:0]       iss_row;
    logic [ADDR_W-1:0]   rbase_q;
    logic                gen_busy;
    logic                mac_busy;
    logic                launch;

    assign idle   = ~gen_busy & ~iss_tag.valid & ~mac_busy;
    assign launch = start & idle;

    matvec_addr_gen #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_gen (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .mat_base   (mat_base),
        .vec_base   (vec_base),
        .res_base   (res_base),
        .mat_addr   (mat_addr),
        .vec_addr   (vec_addr),
        .tag        (iss_tag),
        .tag_row    (iss_row),
        .res_base_q (rbase_q),
        .busy       (gen_busy)
    );

    matvec_mac #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_mac (
        .clk         (clk),
        .rst         (rst),
        .mat_data    (mat_data),
        .vec_data    (vec_data),
        .tag_in      (iss_tag),
        .row_in      (iss_row),
        .res_base_in (rbase_q),
        .res_addr    (res_addr),
        .res_data    (res_data),
        .res_we      (res_we),
        .busy        (mac_busy)
    );

endmodule

// File: rtl/matvec_chk.sv
module matvec_chk #(
    parameter int ROWS   = 4,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              idle,
    input logic [ADDR_W-1:0] mat_base,
    input logic [ADDR_W-1:0] vec_base,
    input logic [ADDR_W-1:0] res_base,
    input logic [ADDR_W-1:0] mat_addr,
    input logic [ADDR_W-1:0] vec_addr,
    input logic [ADDR_W-1:0] res_addr,
    input logic              res_we,
    input logic              iss_v,
    input logic              iss_first,
    input logic              iss_last,
    input logic [(ROWS>1 ? $clog2(ROWS) : 1)-1:0] iss_row
);
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int WW = $clog2(ROWS + 1);

    logic [ADDR_W-1:0] mb_q, vb_q, rb_q;
    logic [WW-1:0]     wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mb_q <= '0; vb_q <= '0; rb_q <= '0; wcnt <= '0;
        end else if (start && idle) begin
            mb_q <= mat_base; vb_q <= vec_base; rb_q <= res_base; wcnt <= '0;
        end else if (res_we) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (idle && !res_we));

    a_r8_idle_drops: assert property (@(posedge clk) disable iff (rst)
        (start && idle) |=> !idle);

    a_r2_mat_origin: assert property (@(posedge clk) disable iff (rst)
        (iss_v && !$past(iss_v)) |-> (mat_addr == mb_q));

    a_r2_mat_step: assert property (@(posedge clk) disable iff (rst)
        (iss_v && $past(iss_v)) |-> (mat_addr == ADDR_W'($past(mat_addr) + 1)));

    a_r3_vec_restart: assert property (@(posedge clk) disable iff (rst)
        (iss_v && iss_first) |-> (vec_addr == vb_q));

    a_r3_vec_step: assert property (@(posedge clk) disable iff (rst)
        (iss_v && !iss_first && $past(iss_v)) |-> (vec_addr == ADDR_W'($past(vec_addr) + 1)));

    a_r4_write_addr: assert property (@(posedge clk) disable iff (rst)
        res_we |-> (res_addr == ADDR_W'(rb_q + ADDR_W'(wcnt))));

    a_r4_write_count: assert property (@(posedge clk) disable iff (rst)
        res_we |-> (wcnt < WW'(ROWS)));

    a_r7_stream_unbroken: assert property (@(posedge clk) disable iff (rst)
        (iss_v && !(iss_last && iss_row == RW'(ROWS - 1))) |=> iss_v);

endmodule

bind matvec_top matvec_chk #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .idle      (idle),
    .mat_base  (mat_base),
    .vec_base  (vec_base),
    .res_base  (res_base),
    .mat_addr  (mat_addr),
    .vec_addr  (vec_addr),
    .res_addr  (res_addr),
    .res_we    (res_we),
    .iss_v     (iss_tag.valid),
    .iss_first (iss_tag.first),
    .iss_last  (iss_tag.last),
    .iss_row   (iss_row)
);

// File: tb/tb_matvec_top.sv
module tb_matvec_top;
    localparam int ROWS   = 4;
    localparam int COLS   = 3 * ROWS;
    localparam int ADDR_W = 10;
    localparam int MEM_N  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] mat_base = '0, vec_base = '0, res_base = '0;
    logic [ADDR_W-1:0] mat_addr, vec_addr, res_addr;
    logic [15:0]       mat_data, vec_data, res_data;
    logic              res_we, idle;

    logic [15:0] mat_mem [MEM_N];
    logic [15:0] vec_mem [MEM_N];

    typedef struct {
        logic [ADDR_W-1:0] a;
        logic [15:0]       d;
        string             req;
    } sb_item_t;

    sb_item_t sb[$];
    int checks = 0;
    int errors = 0;
    int writes = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    matvec_top #(.ROWS(ROWS), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .start(start),
        .mat_base(mat_base), .vec_base(vec_base), .res_base(res_base),
        .mat_addr(mat_addr), .vec_addr(vec_addr),
        .mat_data(mat_data), .vec_data(vec_data),
        .res_addr(res_addr), .res_data(res_data), .res_we(res_we), .idle(idle)
    );

    // Synchronous read memories, one cycle latency.
    always_ff @(posedge clk) begin
        mat_data <= mat_mem[mat_addr];
        vec_data <= vec_mem[vec_addr];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pop and compare every write.
    always @(negedge clk) begin
        if (!rst && res_we) begin
            writes++;
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected write at addr", longint'(res_addr), -1);
            end else begin
                sb_item_t it;
                it = sb.pop_front();
                check(res_addr == it.a, "R4", "write address", longint'(res_addr), longint'(it.a));
                check(res_data == it.d, it.req, "row result",
                      longint'($signed(res_data)), longint'($signed(it.d)));
            end
        end
    end

    function automatic logic [15:0] model_row(input int mb, input int vb, input int r);
        longint s = 0;
        longint q;
        for (int c = 0; c < COLS; c++) begin
            s += longint'($signed(mat_mem[(mb + r*COLS + c) % MEM_N])) *
                 longint'($signed(vec_mem[(vb + c) % MEM_N]));
        end
        q = (s + 16384) >>> 15;
        if (q > 32767)  q = 32767;
        if (q < -32768) q = -32768;
        return q[15:0];
    endfunction

    task automatic run_job(input int mb, input int vb, input int rb,
                           input string req, input bit poke_busy);
        int w0;
        int n;
        for (int r = 0; r < ROWS; r++) begin
            sb_item_t it;
            it.a   = ADDR_W'(rb + r);
            it.d   = model_row(mb, vb, r);
            it.req = req;
            sb.push_back(it);
        end
        w0 = writes;
        @(negedge clk);
        mat_base = ADDR_W'(mb); vec_base = ADDR_W'(vb); res_base = ADDR_W'(rb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(idle == 1'b0, "R8", "idle after start", longint'(idle), 0);
        if (poke_busy) begin
            repeat (5) @(negedge clk);
            mat_base = ADDR_W'(mb + 7); vec_base = ADDR_W'(vb + 3); res_base = ADDR_W'(rb + 100);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!idle && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(idle == 1'b1, "R8", "idle at job end", longint'(idle), 1);
        check(sb.size() == 0, "R4", "pending results", sb.size(), 0);
        check(writes - w0 == ROWS, "R4", "writes per job", writes - w0, ROWS);
        if (poke_busy) begin
            repeat (12) @(negedge clk);
            check(idle == 1'b1 && writes - w0 == ROWS, "R7", "no job after busy start",
                  writes - w0, ROWS);
        end
        sb.delete();
    endtask

    initial begin
        for (int i = 0; i < MEM_N; i++) begin
            mat_mem[i] = '0;
            vec_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        check(idle == 1'b1, "R1", "idle in reset", longint'(idle), 1);
        check(res_we == 1'b0, "R1", "res_we in reset", longint'(res_we), 0);
        rst = 1'b0;
        @(negedge clk);
        check(idle == 1'b1 && res_we == 1'b0, "R1", "quiet after reset", longint'(idle), 1);

        // Mixed values, offset bases (R2, R3, R4, R6).
        for (int i = 0; i < ROWS*COLS; i++)
            mat_mem[16 + i] = 16'(((i*37) % 200 - 100) * 150);
        for (int c = 0; c < COLS; c++)
            vec_mem[300 + c] = 16'(((c*53) % 180 - 90) * 300);
        run_job(16, 300, 500, "R2", 1'b0);

        // Same vector, matrix shifted so rows differ from the last job (R6).
        run_job(20, 300, 520, "R6", 1'b0);

        // Saturation and full-precision accumulation (R5, R9).
        for (int c = 0; c < COLS; c++) begin
            vec_mem[600 + c]            = 16'h8000;
            mat_mem[100 + c]            = 16'h8000;        // +12  -> clamp high
            mat_mem[100 + COLS + c]     = 16'h7FFF;        // ~-12 -> clamp low
            mat_mem[100 + 2*COLS + c]   = 16'h0000;
            mat_mem[100 + 3*COLS + c]   = (c % 2 == 0) ? 16'h8000 : 16'h7FFF; // R9 -> 6
        end
        check(model_row(100, 600, 3) == 16'd6, "R9", "model sanity", longint'(model_row(100, 600, 3)), 6);
        run_job(100, 600, 700, "R5", 1'b0);

        // Rounding at exactly half an LSB (R4).
        for (int c = 0; c < COLS; c++) vec_mem[800 + c] = 16'h4000;
        for (int i = 0; i < ROWS*COLS; i++) mat_mem[200 + i] = 16'h0000;
        mat_mem[200 + 0*COLS] = 16'sd1;   // -> 1
        mat_mem[200 + 1*COLS] = -16'sd1;  // -> 0
        mat_mem[200 + 2*COLS] = 16'sd3;   // -> 2
        mat_mem[200 + 3*COLS] = -16'sd3;  // -> -1
        run_job(200, 800, 900, "R4", 1'b0);

        // Start while busy is ignored (R7), matrix wrapping the address space (R2).
        for (int i = 0; i < ROWS*COLS; i++)
            mat_mem[(1000 + i) % MEM_N] = 16'((i * 911) % 4000 - 2000);
        run_job(1000, 300, 40, "R7", 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule